// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the digital model of a 2048 x 8 non-volatile memory that sits on a two-wire serial bus as a slave. The bus clock and data lines are oversampled by the system clock. The block recognises the bus START and STOP conditions, decodes a control byte and a word address, and then serves either a write or a read. Its data line is open-drain: the block only ever asserts an enable that pulls the line low, and an external pull-up supplies the high level.

Writes go into a one-page buffer of 16 bytes. When the master issues a STOP after at least one complete data byte, the buffer is committed to the array during an internal write window. The window's length is a parameter in system clock cycles. During the window the block ignores the bus and acknowledges nothing, so the master can poll with control bytes until it sees an acknowledge. Reads return successive bytes for as long as the master acknowledges them. A random read is a write phase that carries only the address, followed by a repeated START with the read bit set.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the pull-low enable is deasserted, and it stays deasserted while no transfer is addressed to the block.
- R2: A control byte whose upper four bits are 1010 is acknowledged, with the line held low through the ninth clock. Bits 3..1 of that byte give address bits 10..8, and bit 0 is 1 for a read. A control byte with any other upper nibble is not acknowledged, and the block ignores the bus until the next START.
- R3: The byte that follows a write control byte sets address bits 7..0. A data byte written to an address and then fetched by a random read (address-only write, repeated START, read control byte) comes back unchanged.
- R4: Within one write, successive data bytes go to successive addresses whose low four bits wrap from 15 to 0 while bits 10..4 stay fixed. A write of more than 16 bytes overwrites the earliest bytes of the same page, and locations outside that page are unchanged.
- R5: In a read, each byte the master acknowledges advances the full 11-bit address, and the address wraps from 2047 to 0.
- R6: A not-acknowledge from the master ends the read. The block then stays off the line, even if further clocks arrive, until a new START.
- R7: A STOP that arrives before any data byte is complete starts no write cycle. The block acknowledges its next control byte at once, and the array is unchanged.
- R8: After a STOP that closes a write of at least one complete byte, the block pulls the line for nothing during WR_CYCLES system clocks. Control bytes sent during that window get no acknowledge. After the window, a control byte is acknowledged again.
- R9: A STOP at any point of a transfer that is not a write commit returns the block to standby with the line released. The next transfer works normally.
- R10: The block sends read data MSB first. It pulls the line low for a 0 bit and releases it for a 1 bit, and it changes its pull-low enable only while the sampled bus clock is low, except when reacting to a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (wired-AND level) |
| sda_pull_o | output | 1 | When high, the block pulls the data line low |

## Verification
The bench targets the page boundary: it writes 18 bytes starting mid-page. A design that carried into address bit 4 would corrupt the next page, and one that did not wrap would lose the last two bytes. Another read crosses 2047 to 0, which a counter limited to the page would get wrong. A busy poll issued just after a write commit must see no acknowledge, and a second poll after the window must see one. A design that committed on a STOP with only a partial data byte, or that kept driving after a master NACK or after an aborting STOP, shows up as a wrong acknowledge, a corrupted read or a pull seen while the block should be silent.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_p    <= scl_sync[1];
      sda_p    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock is high on both samples
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int         PAGE     = 1 << PAGE_W;
  localparam int         BLK_W    = ADDR_W - BYTE_W;
  localparam int         CNT_W    = $clog2(WR_CYCLES + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  // address arithmetic kept in functions
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    page_next = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    seq_next = a + ADDR_W'(1);
  endfunction

  // named bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  eep_bus_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_state_e         state_q;
  logic [3:0]         bitn_q;
  logic [BYTE_W-1:0]  sh_q;
  logic               pull_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BLK_W-1:0]   blk_q;
  logic               rd_q;
  logic               got_data_q;
  logic               busy_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic [BYTE_W-1:0]  buf_q [PAGE];
  logic [PAGE-1:0]    valid_q;

  // commit path: one buffered byte per clock at the start of the window
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [BYTE_W-1:0] commit_data;
  logic [BYTE_W-1:0] mem_rd;

  assign commit_we   = busy_q && (wcnt_q < CNT_W'(PAGE)) && valid_q[wcnt_q[PAGE_W-1:0]];
  assign commit_addr = {addr_q[ADDR_W-1:PAGE_W], wcnt_q[PAGE_W-1:0]};
  assign commit_data = buf_q[wcnt_q[PAGE_W-1:0]];

  eep_array #(.AW(ADDR_W), .DW(BYTE_W)) u_array (
    .clk   (clk),
    .we    (commit_we),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr (addr_q),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitn_q     <= '0;
      sh_q       <= '0;
      pull_q     <= 1'b0;
      addr_q     <= '0;
      blk_q      <= '0;
      rd_q       <= 1'b0;
      got_data_q <= 1'b0;
      busy_q     <= 1'b0;
      wcnt_q     <= '0;
      valid_q    <= '0;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= '0;
    end else if (busy_q) begin
      // internal write window: bus fully ignored
      wcnt_q <= wcnt_q + 1'b1;
      if (wcnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_q  <= 1'b0;
        valid_q <= '0;
      end
    end else if (stop_evt) begin
      state_q    <= ST_IDLE;
      pull_q     <= 1'b0;
      got_data_q <= 1'b0;
      if (got_data_q) begin
        busy_q <= 1'b1;
        wcnt_q <= '0;
      end
    end else if (start_evt) begin
      state_q    <= ST_CTRL;
      bitn_q     <= '0;
      pull_q     <= 1'b0;
      got_data_q <= 1'b0;
      valid_q    <= '0;
    end else begin
      case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitn_q < 4'd8) begin
            sh_q   <= {sh_q[BYTE_W-2:0], sda_s};
            bitn_q <= bitn_q + 1'b1;
          end else if (scl_fall && bitn_q == 4'd8) begin
            bitn_q <= '0;
            if (state_q == ST_CTRL) begin
              if (sh_q[7:4] == DEV_CODE) begin
                pull_q  <= 1'b1;
                blk_q   <= sh_q[BLK_W:1];
                rd_q    <= sh_q[0];
                state_q <= ST_CACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              pull_q  <= 1'b1;
              addr_q  <= {blk_q, sh_q};
              valid_q <= '0;
              state_q <= ST_AACK;
            end else begin
              pull_q                       <= 1'b1;
              buf_q[addr_q[PAGE_W-1:0]]    <= sh_q;
              valid_q[addr_q[PAGE_W-1:0]]  <= 1'b1;
              addr_q                       <= page_next(addr_q);
              got_data_q                   <= 1'b1;
              state_q                      <= ST_WACK;
            end
          end
        end
        ST_CACK: begin
          if (scl_fall) begin
            bitn_q <= '0;
            if (rd_q) begin
              sh_q    <= mem_rd;
              pull_q  <= ~mem_rd[BYTE_W-1];
              state_q <= ST_RDATA;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_ADDR;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            pull_q  <= 1'b0;
            bitn_q  <= '0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitn_q < 4'd7) begin
              sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
              pull_q <= ~sh_q[BYTE_W-2];
              bitn_q <= bitn_q + 1'b1;
            end else begin
              pull_q  <= 1'b0;
              bitn_q  <= '0;
              state_q <= ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            addr_q <= seq_next(addr_q);
            if (sda_s) state_q <= ST_IDLE;
            else       bitn_q  <= 4'd1;
          end else if (scl_fall && bitn_q == 4'd1) begin
            sh_q    <= mem_rd;
            pull_q  <= ~mem_rd[BYTE_W-1];
            bitn_q  <= '0;
            state_q <= ST_RDATA;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  // ---------------- assertions ----------------
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull_o);

  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !sda_pull_o);

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (addr_q == $past(addr_q)));

  assert_stop_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !busy_q) |=> (state_q == ST_IDLE && !sda_pull_o));

  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_s));
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int WR = 1500;
  localparam int Q  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_o;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int quiet_hits = 0;
  logic quiet = 1'b0;

  logic [7:0] ref_mem [2048];
  logic [7:0] wdat [$];

  always #10 clk = ~clk;   // 50 MHz

  assign sda_line = m_sda & ~sda_pull_o;

  serial_eeprom_slave #(.WR_CYCLES(WR)) i_serial_eeprom_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull_o)
  );

  // per-clock comparison: where the model says silent, the pull must be off
  always @(posedge clk) if (quiet && sda_pull_o) quiet_hits++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    acked = !sda_line;
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input int a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  // write wdat starting at a; page wrap modelled as (start + i) mod 16
  task automatic do_write(input int a, input logic wait_done);
    logic ack;
    int base;
    bus_start;
    send_byte(ctrl(a, 1'b0), ack); chk("R2 ctrl ack", ack, 1);
    send_byte(a[7:0], ack);        chk("R3 addr ack", ack, 1);
    base = a & 'h7F0;
    for (int i = 0; i < wdat.size(); i++) begin
      send_byte(wdat[i], ack);     chk("R4 data ack", ack, 1);
      ref_mem[base + ((a + i) % 16)] = wdat[i];
    end
    bus_stop;
    if (wait_done) wq(WR + 200);
  endtask

  task automatic set_addr_and_read(input int a);
    logic ack;
    bus_start;
    send_byte(ctrl(a, 1'b0), ack);
    send_byte(a[7:0], ack);
    bus_start;
    send_byte(ctrl(a, 1'b1), ack); chk("R3 read ctrl ack", ack, 1);
  endtask

  // random + sequential read, each byte compared to the model (R3, R5, R10)
  task automatic do_read(input int a, input int n, input string req);
    logic [7:0] got;
    set_addr_and_read(a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, got);
      chk(req, got, ref_mem[(a + i) % 2048]);
    end
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] got;

    wq(10);
    rst_n = 1'b1;
    wq(5);
    chk("R1 reset release", sda_pull_o, 0);

    // R8: byte write then busy polling
    wdat.delete(); wdat.push_back(8'hA5);
    do_write('h123, 1'b0);
    quiet = 1'b1;
    bus_start;
    send_byte(ctrl('h123, 1'b0), ack); chk("R8 no ack while busy", ack, 0);
    bus_stop;
    wq(WR);
    quiet = 1'b0;
    chk("R8 silent during write window", quiet_hits, 0);
    bus_start;
    send_byte(ctrl('h123, 1'b0), ack); chk("R8 ack after window", ack, 1);
    bus_stop;

    do_read('h123, 1, "R3 random read");

    // R6: NACK ends the read; extra clocks read back all ones
    set_addr_and_read('h123);
    recv_byte(1'b0, got); chk("R6 byte before nack", got, 8'hA5);
    quiet = 1'b1;
    recv_byte(1'b0, got); chk("R6 released after nack", got, 8'hFF);
    bus_stop;
    quiet = 1'b0;
    chk("R6 no pull after nack", quiet_hits, 0);

    // R2: foreign device code
    quiet = 1'b1;
    bus_start;
    send_byte(8'hB2, ack); chk("R2 foreign code nack", ack, 0);
    send_byte(8'h00, ack); chk("R2 ignored until start", ack, 0);
    bus_stop;
    quiet = 1'b0;
    chk("R2 silent for foreign code", quiet_hits, 0);

    // R4/R5: page wrap and neighbours
    wdat.delete(); wdat.push_back(8'h3C); do_write('h7EF, 1'b1);
    wdat.delete(); wdat.push_back(8'h5C); do_write('h000, 1'b1);
    wdat.delete();
    for (int i = 0; i < 18; i++) wdat.push_back(8'(8'h10 + i));
    do_write('h7F4, 1'b1);
    do_read('h7F0, 16, "R4 page contents");
    do_read('h7EF, 1,  "R4 outside page");
    do_read('h7FE, 3,  "R5 wrap 2047 to 0");

    // R7: STOP inside the first data byte
    bus_start;
    send_byte(ctrl('h7F5, 1'b0), ack);
    send_byte(8'hF5, ack);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
    end
    bus_stop;
    bus_start;
    send_byte(ctrl('h7F5, 1'b0), ack); chk("R7 not busy after partial", ack, 1);
    bus_stop;
    do_read('h7F5, 1, "R7 array unchanged");

    // R9: STOP inside a read byte (value at 0x7F0 is 0x1C, fourth bit is 1)
    set_addr_and_read('h7F0);
    for (int i = 0; i < 3; i++) begin
      wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0;
    end
    wq(Q);
    bus_stop;
    quiet = 1'b1;
    wq(200);
    quiet = 1'b0;
    chk("R9 standby after abort", quiet_hits, 0);
    chk("R9 line released", sda_pull_o, 0);
    do_read('h7F0, 1, "R9 usable after abort");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule